// File: doc/BRIEF.md
# PCI Target Address Region Decoder

This block resolves the address phase of an inbound PCI transaction against a small bank of programmable target windows. Each window holds a base address, a compare mask and a five-bit attribute set. One clock after an address phase is presented, the block reports:

- whether the transaction hits;
- which window won;
- that window's attributes;
- how the target engine must treat the transfer. Reads to non-prefetchable space are cut off after one 32-bit word. Prefetchable reads fetch a programmed number of words. Eligible memory writes may be posted.

A narrow configuration write port loads the windows and a global control word. The global control word holds an enable for prefetching the I/O data port at 0x1F0 and a read-threshold count. The target state machine uses the registered outputs to pick its termination and its prefetch depth.

Top module: `pci_region_decoder`

## Requirements
- R1: After reset every output is 0. `dec_valid` is 1 exactly in the cycle after a cycle with `ap_valid` high. All decode outputs reflect the address phase sampled at that edge, and the configuration held before it.
- R2: A window is a candidate when `((ap_addr ^ base) & mask) == 0`. A mask bit of 1 makes that address bit compared, and a mask bit of 0 makes it ignored.
- R3: A window whose attribute bit 0 (enable) is 0 never hits.
- R4: Attribute bit 1 selects the window's space: 1 for I/O, 0 for memory.
  - Memory commands (0110, 0111, 1100, 1110, 1111) hit only memory windows.
  - I/O commands (0010, 0011) hit only I/O windows.
  - Every other command never hits.
- R5: When several windows qualify, the lowest index wins. `dec_region` and `dec_attr` carry the winner's index and attributes. On a miss, both are 0 and `dec_hit` is 0.
- R6: On a hitting read (0010, 0110, 1100, 1110) with the winner's prefetch attribute (bit 2) clear, `dec_single` is 1 and `dec_fetch` is 1.
- R7: On a hitting read treated as prefetchable, `dec_single` is 0 and `dec_fetch` is the threshold field plus one. On a miss or a non-read, `dec_fetch` is 0 and `dec_single` is 0.
- R8: The prefetch enable (global bit 0) forces prefetch treatment only when all of the following hold:
  - the transaction is a hitting I/O read (0010);
  - `ap_addr` is exactly 0x1F0;
  - `ap_be_n` is 0000.

  Any other byte-enable pattern leaves the window's own attribute in force.
- R9: `dec_post` is 1 only for a hitting memory write (0111, 1111) whose winner has the postable attribute (bit 4). Attribute bit 3 (retry/hold) is reported in `dec_attr` and does not affect any other output.
- R10: A configuration write with `cfg_we` high selects its target from `cfg_addr`:
  - bits [1:0] pick the field: 0 for base, 1 for mask, 2 for attributes (low five bits), 3 for global;
  - bits above [1:0] pick the window.

  A global write stores the prefetch enable from bit 0 and the threshold from bits [THR_W:1], whatever window is named.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | RW+2 | Window index and field select |
| cfg_wdata | input | AW | Configuration write data |
| ap_valid | input | 1 | Address phase present |
| ap_addr | input | AW | Transaction address |
| ap_cmd | input | 4 | PCI bus command |
| ap_be_n | input | 4 | Byte enables, active low |
| dec_valid | output | 1 | Registered decode result valid |
| dec_hit | output | 1 | Some window claimed the transaction |
| dec_region | output | RW | Winning window index |
| dec_attr | output | 5 | Winning window attributes |
| dec_single | output | 1 | Disconnect after one word |
| dec_fetch | output | THR_W+1 | Words to fetch for a read |
| dec_post | output | 1 | Write may be posted |

## Verification
The bench builds the block with its defaults: four windows, 32-bit addresses and a three-bit threshold. This lets a threshold of up to eight words, and every window index, be reached. The windows are laid out so that two memory windows overlap and priority decides between them. One window holds the 0x1F0 port, and one is programmed but disabled. Decoding runs with the port prefetch on, and again with it off. The bench then clears the winning window, so a later window takes over the addresses it had claimed.

// File: rtl/pci_region_decoder.sv
module pci_region_decoder #(
  parameter int NREG  = 4,
  parameter int AW    = 32,
  parameter int THR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [((NREG>1)?$clog2(NREG):1)+1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              ap_valid,
  input  logic [AW-1:0]     ap_addr,
  input  logic [3:0]        ap_cmd,
  input  logic [3:0]        ap_be_n,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic [((NREG>1)?$clog2(NREG):1)-1:0] dec_region,
  output logic [4:0]        dec_attr,
  output logic              dec_single,
  output logic [THR_W:0]    dec_fetch,
  output logic              dec_post
);
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int FW = THR_W + 1;

  logic [AW-1:0]    base_q [NREG];
  logic [AW-1:0]    mask_q [NREG];
  logic [4:0]       attr_q [NREG];
  logic             ide_q;
  logic [THR_W-1:0] thr_q;

  logic [1:0]    cfg_field;
  logic [RW-1:0] cfg_idx;
  assign cfg_field = cfg_addr[1:0];
  assign cfg_idx   = cfg_addr[RW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        attr_q[i] <= '0;
      end
      ide_q <= 1'b0;
      thr_q <= '0;
    end else if (cfg_we) begin
      if (cfg_field == 2'd3) begin
        ide_q <= cfg_wdata[0];
        thr_q <= cfg_wdata[THR_W:1];
      end else begin
        for (int i = 0; i < NREG; i++) begin
          if (cfg_idx == RW'(i)) begin
            if (cfg_field == 2'd0) base_q[i] <= cfg_wdata;
            if (cfg_field == 2'd1) mask_q[i] <= cfg_wdata;
            if (cfg_field == 2'd2) attr_q[i] <= cfg_wdata[4:0];
          end
        end
      end
    end
  end

  logic is_mem, is_io, is_rd, is_memwr;
  assign is_mem   = (ap_cmd == 4'b0110) || (ap_cmd == 4'b0111) || (ap_cmd == 4'b1100) ||
                    (ap_cmd == 4'b1110) || (ap_cmd == 4'b1111);
  assign is_io    = (ap_cmd == 4'b0010) || (ap_cmd == 4'b0011);
  assign is_rd    = (ap_cmd == 4'b0010) || (ap_cmd == 4'b0110) || (ap_cmd == 4'b1100) ||
                    (ap_cmd == 4'b1110);
  assign is_memwr = (ap_cmd == 4'b0111) || (ap_cmd == 4'b1111);

  logic [NREG-1:0] hitv;
  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign hitv[g] = attr_q[g][0] && (attr_q[g][1] ? is_io : is_mem) &&
                     (((ap_addr ^ base_q[g]) & mask_q[g]) == '0);
  end

  logic [RW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (hitv[i]) sel = RW'(i);
  end

  logic       any_hit, ide_case, eff_pf;
  logic [4:0] sel_attr;
  logic [FW-1:0] fetch_d;
  assign any_hit  = |hitv;
  assign sel_attr = any_hit ? attr_q[sel] : 5'd0;
  assign ide_case = ide_q && (ap_cmd == 4'b0010) && (ap_addr == AW'('h1F0)) && (ap_be_n == 4'b0000);
  assign eff_pf   = sel_attr[2] || ide_case;
  assign fetch_d  = !(any_hit && is_rd) ? '0 :
                    eff_pf ? (FW'(thr_q) + FW'(1)) : FW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_hit    <= 1'b0;
      dec_region <= '0;
      dec_attr   <= '0;
      dec_single <= 1'b0;
      dec_fetch  <= '0;
      dec_post   <= 1'b0;
    end else begin
      dec_valid  <= ap_valid;
      dec_hit    <= ap_valid && any_hit;
      dec_region <= (ap_valid && any_hit) ? sel : '0;
      dec_attr   <= ap_valid ? sel_attr : '0;
      dec_single <= ap_valid && any_hit && is_rd && !eff_pf;
      dec_fetch  <= ap_valid ? fetch_d : '0;
      dec_post   <= ap_valid && any_hit && is_memwr && sel_attr[4];
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_valid |=> dec_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_valid |=> (!dec_valid && !dec_hit && !dec_post && dec_fetch == '0));
  // R3
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (dec_valid && dec_attr[0]));
  // R6
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_single |-> (dec_hit && dec_fetch == FW'(1) && !dec_attr[2]));
  // R9
  post_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_post |-> (dec_hit && dec_attr[4] && !dec_attr[1] && dec_fetch == '0));
  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_region == '0 && dec_attr == '0));
endmodule

// File: tb/pci_region_decoder_tb.sv
module pci_region_decoder_tb;
  localparam int NREG = 4, AW = 32, THR_W = 3, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [RW+1:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0, ap_addr = '0;
  logic ap_valid = 1'b0;
  logic [3:0] ap_cmd = '0, ap_be_n = '0;
  logic dec_valid, dec_hit, dec_single, dec_post;
  logic [RW-1:0] dec_region;
  logic [4:0] dec_attr;
  logic [THR_W:0] dec_fetch;

  always #5 clk = ~clk;

  pci_region_decoder #(.NREG(NREG), .AW(AW), .THR_W(THR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ap_valid(ap_valid), .ap_addr(ap_addr), .ap_cmd(ap_cmd), .ap_be_n(ap_be_n),
    .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_region(dec_region), .dec_attr(dec_attr),
    .dec_single(dec_single), .dec_fetch(dec_fetch), .dec_post(dec_post));

  int n_cmp = 0, n_bad = 0;
  bit started = 0, done = 0;

  logic [31:0] mb [NREG];
  logic [31:0] mm [NREG];
  logic [4:0]  ma [NREG];
  bit mide;
  int mthr;

  bit e_valid, e_hit, e_single, e_post;
  int e_region, e_attr, e_fetch;

  function automatic bit cmd_in(input logic [3:0] c, input int kind);
    case (kind)
      0: return c inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
      1: return c inside {4'h2, 4'h3};
      2: return c inside {4'h2, 4'h6, 4'hC, 4'hE};
      default: return c inside {4'h7, 4'hF};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_hit = 0; e_region = 0; e_attr = 0; e_single = 0; e_fetch = 0; e_post = 0;
      for (int i = 0; i < NREG; i++) begin mb[i] = 0; mm[i] = 0; ma[i] = 0; end
      mide = 0; mthr = 0;
    end else begin
      bit found, pf;
      int w;
      found = 0; w = 0;
      for (int i = 0; i < NREG; i++) begin
        bit sp;
        sp = ma[i][1] ? cmd_in(ap_cmd, 1) : cmd_in(ap_cmd, 0);
        if (!found && ma[i][0] && sp && (((ap_addr ^ mb[i]) & mm[i]) == 0)) begin
          found = 1; w = i;
        end
      end
      e_valid = ap_valid;
      e_hit = ap_valid && found;
      e_region = e_hit ? w : 0;
      e_attr = e_hit ? int'(ma[w]) : 0;
      pf = e_hit && (ma[w][2] || (mide && ap_cmd == 4'h2 && ap_addr == 32'h1F0 && ap_be_n == 0));
      e_single = e_hit && cmd_in(ap_cmd, 2) && !pf;
      e_fetch = (e_hit && cmd_in(ap_cmd, 2)) ? (pf ? mthr + 1 : 1) : 0;
      e_post = e_hit && cmd_in(ap_cmd, 3) && ma[w][4];
      if (cfg_we) begin
        if (cfg_addr[1:0] == 3) begin mide = cfg_wdata[0]; mthr = int'(cfg_wdata[3:1]); end
        else if (cfg_addr[1:0] == 0) mb[cfg_addr[3:2]] = cfg_wdata;
        else if (cfg_addr[1:0] == 1) mm[cfg_addr[3:2]] = cfg_wdata;
        else ma[cfg_addr[3:2]] = cfg_wdata[4:0];
      end
      started = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && started && !done) begin
    chk("R1 valid", int'(dec_valid), int'(e_valid));
    chk("R2 hit", int'(dec_hit), int'(e_hit));
    chk("R5 region", int'(dec_region), e_region);
    chk("R5 attr", int'(dec_attr), e_attr);
    chk("R6 single", int'(dec_single), int'(e_single));
    chk("R7 fetch", int'(dec_fetch), e_fetch);
    chk("R9 post", int'(dec_post), int'(e_post));
  end

  task automatic cfg(input int idx, input int fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(idx * 4 + fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ap(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be);
    @(negedge clk);
    ap_valid = 1; ap_addr = a; ap_cmd = c; ap_be_n = be;
    @(negedge clk);
    ap_valid = 0;
  endtask

  task automatic burst(input int n);
    logic [31:0] bases [5] = '{32'h8000_0000, 32'h8050_0000, 32'h0000_01F0, 32'hC000_0000, 32'h0000_1000};
    logic [3:0] cmds [8] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'hA};
    for (int k = 0; k < n; k++) begin
      int b;
      logic [31:0] a;
      b = $urandom_range(0, 4);
      a = (b == 2) ? bases[b] + 32'($urandom_range(0, 9)) :
          bases[b] + ($urandom_range(0, 3) == 0 ? 0 : (32'($urandom) & 32'h00FF_FFFC));
      @(negedge clk);
      ap_valid = ($urandom_range(0, 4) != 0);
      ap_addr = a;
      ap_cmd = cmds[$urandom_range(0, 7)];
      ap_be_n = ($urandom_range(0, 1) == 0) ? 4'h0 : 4'($urandom_range(0, 15));
    end
    @(negedge clk);
    ap_valid = 0;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, all outputs zero
    chk("R1 reset", int'({dec_valid, dec_hit, dec_region, dec_attr, dec_single, dec_fetch, dec_post}), 0);
    rst_n = 1;
    // R10: program windows and global control
    cfg(0, 0, 32'h8000_0000); cfg(0, 1, 32'hFFF0_0000); cfg(0, 2, 32'h15);
    cfg(1, 0, 32'h8000_0000); cfg(1, 1, 32'hFF00_0000); cfg(1, 2, 32'h19);
    cfg(2, 0, 32'h0000_01F0); cfg(2, 1, 32'hFFFF_FFF8); cfg(2, 2, 32'h03);
    cfg(3, 0, 32'hC000_0000); cfg(3, 1, 32'hF000_0000); cfg(3, 2, 32'h14);
    cfg(1, 3, 32'd11);
    // R2/R5: overlap, window 0 wins; R7 prefetch read
    ap(32'h8001_2340, 4'h6, 4'h0);
    // R6: window 1 non-prefetchable read
    ap(32'h8070_0000, 4'hC, 4'h0);
    // R9: postable memory write
    ap(32'h8070_0000, 4'h7, 4'h0);
    // R3: disabled window
    ap(32'hC000_0010, 4'h6, 4'h0);
    // R4: memory command to I/O window, config command
    ap(32'h0000_01F0, 4'h6, 4'h0);
    ap(32'h8000_0000, 4'hA, 4'h0);
    // R8: port prefetch with full and partial byte enables
    ap(32'h0000_01F0, 4'h2, 4'h0);
    ap(32'h0000_01F0, 4'h2, 4'h3);
    ap(32'h0000_01F4, 4'h2, 4'h0);
    burst(3000);
    // R8 off, threshold 0
    cfg(0, 3, 32'd0);
    ap(32'h0000_01F0, 4'h2, 4'h0);
    burst(2000);
    // R3/R5: disable window 0, window 1 takes over
    cfg(0, 2, 32'h14);
    cfg(2, 3, 32'd15);
    ap(32'h8001_2340, 4'h6, 4'h0);
    burst(3000);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule